// File: doc/BRIEF.md
# Two-Digit Decimal (BCD) Adder with Invalid-Digit Flag

This block adds two unsigned decimal numbers of two digits each, where every digit is held as a 4-bit binary-coded-decimal nibble, and returns a three-digit decimal sum. A carry input is added into the lowest digit, so the largest result is 99 + 99 + 1 = 199. The block has no clock and no state, and its outputs follow its inputs within the same cycle.

The adder is a chain of identical digit cells. Each cell forms the plain binary sum of its two digits and the incoming carry with a ripple-carry adder built from full adders. It then checks whether that 5-bit total is above nine. If it is, the cell brings the digit back into the range 0..9 and passes a decimal carry to the next cell. The carry out of the top cell becomes the hundreds digit. A parameter selects how the cell brings the digit back into range: by adding six modulo sixteen, or by subtracting ten. A separate error output goes high when any operand nibble holds a value from 10 to 15. The sum is not defined while that error output is high.

Top module: `bcd_add2`

## Requirements
- R1: Operand packing: `a[7:4]` and `b[7:4]` are the tens digits and `a[3:0]`, `b[3:0]` the units. The result `sum[11:8]` is the hundreds digit, `sum[7:4]` the tens and `sum[3:0]` the units.
- R2: Each digit cell forms a 5-bit binary total of its two digits plus its carry in. This total holds every value up to 19 without loss.
- R3: When a digit total T is greater than 9, the result digit is T-10 and the cell's decimal carry is 1. Otherwise the result digit is T and the carry is 0.
- R4: The carry from the units cell enters the tens cell. The hundreds digit `sum[11:8]` equals the tens cell's carry, so it is always 0 or 1.
- R5: `cin` is added into the units digit with weight one.
- R6: `err` is 1 exactly when at least one of the four operand nibbles is greater than 9.
- R7: The block is purely combinational. A change on the inputs shows on `sum` and `err` in the same cycle, with zero register stages.
- R8: The extreme case 99 + 99 + 1 gives the sum 1, 9, 9 with `err` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 8 | First operand: tens digit in the upper nibble, units digit in the lower nibble |
| b | input | 8 | Second operand, packed in the same way |
| cin | input | 1 | Carry added into the units digit |
| sum | output | 12 | Three-digit decimal result: hundreds, tens, units |
| err | output | 1 | High when any operand nibble is above nine |

## Verification
Every result of this block is due in the same cycle as its stimulus, because there are no register stages. The bench therefore drives new operands just after a rising edge and samples `sum` and `err` at the following falling edge, half a period later. It compares them there with a decimal model in integers. All 20,000 valid operand and carry combinations are applied, one per cycle. Nibbles 10 to 15 are then swept through each of the four digit positions to check the error flag.

// File: rtl/bcd_pkg.sv
package bcd_pkg;
   localparam int DIGIT_W   = 4;
   localparam int DIGIT_MAX = 9;
   localparam int RADIX     = 10;
   localparam int TOTAL_W   = DIGIT_W + 1;
endpackage

// File: rtl/bcd_full_adder.sv
module bcd_full_adder (
   input  logic x,
   input  logic y,
   input  logic cy_in,
   output logic s,
   output logic cy_out
);
   assign s      = x ^ y ^ cy_in;
   assign cy_out = (x & y) | (cy_in & (x ^ y));
endmodule

// File: rtl/bcd_ripple_adder.sv
module bcd_ripple_adder #(
   parameter int W = 4
) (
   input  logic [W-1:0] x,
   input  logic [W-1:0] y,
   input  logic         cy_in,
   output logic [W-1:0] s,
   output logic         cy_out
);
   if (W < 1) begin : g_bad_width
      $error("bcd_ripple_adder: W must be at least 1");
   end

   logic [W:0] chain;
   assign chain[0] = cy_in;

   for (genvar i = 0; i < W; i++) begin : g_bit
      bcd_full_adder u_fa (
         .x      (x[i]),
         .y      (y[i]),
         .cy_in  (chain[i]),
         .s      (s[i]),
         .cy_out (chain[i+1])
      );
   end

   assign cy_out = chain[W];

   // R2: the ripple chain reproduces the full binary total, carry included
   always_comb begin
      if (!$isunknown({x, y, cy_in})) begin
         p_ripple_total_r2: assert ({cy_out, s} == ({1'b0, x} + {1'b0, y} + (W+1)'(cy_in)))
            else $error("ripple total mismatch");
      end
   end
endmodule

// File: rtl/bcd_digit_cell.sv
module bcd_digit_cell
   import bcd_pkg::*;
#(
   parameter bit ADD_CORR = 1'b1
) (
   input  logic [DIGIT_W-1:0] da,
   input  logic [DIGIT_W-1:0] db,
   input  logic               dc_in,
   output logic [DIGIT_W-1:0] dsum,
   output logic               dc_out,
   output logic               bad
);
   logic [DIGIT_W-1:0] raw;
   logic               raw_cy;
   logic [TOTAL_W-1:0] total;
   logic               over9;
   logic [DIGIT_W-1:0] fixed;

   bcd_ripple_adder #(.W(DIGIT_W)) u_rca (
      .x      (da),
      .y      (db),
      .cy_in  (dc_in),
      .s      (raw),
      .cy_out (raw_cy)
   );

   assign total = {raw_cy, raw};
   // total > 9: bit 4 set, or bit 3 set with bit 2 or bit 1
   assign over9 = total[4] | (total[3] & (total[2] | total[1]));

   if (ADD_CORR) begin : g_add_six
      // T - 10 equals T + 6 in the low four bits
      assign fixed = raw + DIGIT_W'(16 - RADIX);
   end else begin : g_sub_ten
      logic [TOTAL_W-1:0] diff;
      assign diff  = total - TOTAL_W'(RADIX);
      assign fixed = diff[DIGIT_W-1:0];
   end

   assign dsum   = over9 ? fixed : raw;
   assign dc_out = over9;
   assign bad    = (da > DIGIT_W'(DIGIT_MAX)) | (db > DIGIT_W'(DIGIT_MAX));

   // R3: for valid digits the outgoing digit is decimal and digit + 10*carry keeps the total
   always_comb begin
      if (!$isunknown({da, db, dc_in}) && !bad) begin
         p_digit_range_r3: assert (dsum <= DIGIT_W'(DIGIT_MAX))
            else $error("digit out of range");
         p_digit_value_r3: assert ((32'(dsum) + (dc_out ? 32'(RADIX) : 32'd0))
                                   == (32'(da) + 32'(db) + 32'(dc_in)))
            else $error("digit value lost");
      end
   end
endmodule

// File: rtl/bcd_add2.sv
module bcd_add2
   import bcd_pkg::*;
#(
   parameter int NDIG     = 2,
   parameter bit ADD_CORR = 1'b1
) (
   input  logic [NDIG*DIGIT_W-1:0]     a,
   input  logic [NDIG*DIGIT_W-1:0]     b,
   input  logic                        cin,
   output logic [(NDIG+1)*DIGIT_W-1:0] sum,
   output logic                        err
);
   localparam int OP_W = NDIG * DIGIT_W;

   if (NDIG < 1) begin : g_bad_ndig
      $error("bcd_add2: NDIG must be at least 1");
   end

   logic [NDIG:0]   cy;
   logic [NDIG-1:0] bad_dig;

   assign cy[0] = cin;

   for (genvar d = 0; d < NDIG; d++) begin : g_dig
      bcd_digit_cell #(.ADD_CORR(ADD_CORR)) u_cell (
         .da     (a[d*DIGIT_W +: DIGIT_W]),
         .db     (b[d*DIGIT_W +: DIGIT_W]),
         .dc_in  (cy[d]),
         .dsum   (sum[d*DIGIT_W +: DIGIT_W]),
         .dc_out (cy[d+1]),
         .bad    (bad_dig[d])
      );
   end

   assign sum[OP_W +: DIGIT_W] = {{(DIGIT_W-1){1'b0}}, cy[NDIG]};
   assign err = |bad_dig;

   function automatic int dec_val(input logic [(NDIG+1)*DIGIT_W-1:0] v, input int n);
      int acc = 0;
      for (int k = n - 1; k >= 0; k--) acc = acc * RADIX + int'(v[k*DIGIT_W +: DIGIT_W]);
      return acc;
   endfunction

   always_comb begin
      if (!$isunknown({a, b, cin})) begin
         // R4: top digit carries only the final decimal carry
         p_top_digit_r4: assert (sum[OP_W +: DIGIT_W] <= 1)
            else $error("top digit above one");
         // R5: when no error, the decimal value of sum equals a + b + cin
         if (!err) begin
            p_total_value_r5: assert (dec_val(sum, NDIG + 1)
                                      == dec_val({{DIGIT_W{1'b0}}, a}, NDIG)
                                       + dec_val({{DIGIT_W{1'b0}}, b}, NDIG) + int'(cin))
               else $error("decimal total mismatch");
         end
      end
   end
endmodule

// File: tb/sim_bcd_add2.sv
module sim_bcd_add2;
   localparam int CLK_PERIOD = 10;
   localparam int MAX_CYCLES = 200000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  a = '0;
   logic [7:0]  b = '0;
   logic        cin = 1'b0;
   logic [11:0] sum;
   logic        err;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit done   = 1'b0;

   bcd_add2 u0 (.a(a), .b(b), .cin(cin), .sum(sum), .err(err));

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles >= MAX_CYCLES && !done) begin
         done = 1'b1;
         errors++;
         checks++;
         $display("FAIL watchdog: act=%0d cycles exp=<%0d", cycles, MAX_CYCLES);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: act=%0d exp=%0d (a=%h b=%h cin=%0b)", req, act, exp, a, b, cin);
      end
   endtask

   // drive just after a rising edge, sample at the next falling edge (R7: zero stages)
   task automatic drive(input int ah, input int al, input int bh, input int bl, input bit c);
      @(posedge clk);
      #1;
      a   = {4'(ah), 4'(al)};
      b   = {4'(bh), 4'(bl)};
      cin = c;
      @(negedge clk);
   endtask

   task automatic valid_case(input int ah, input int al, input int bh, input int bl, input bit c);
      int total;
      drive(ah, al, bh, bl, c);
      total = (ah*10 + al) + (bh*10 + bl) + int'(c);
      check(int'(sum[3:0])  == total % 10,        "R3 R5 units",  int'(sum[3:0]),  total % 10);
      check(int'(sum[7:4])  == (total / 10) % 10, "R3 R4 tens",   int'(sum[7:4]),  (total / 10) % 10);
      check(int'(sum[11:8]) == total / 100,       "R4 hundreds",  int'(sum[11:8]), total / 100);
      check(err == 1'b0,                          "R6 no error",  int'(err), 0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      rst_n = 1'b1;

      // zero inputs give a zero result, R1 packing
      drive(0, 0, 0, 0, 1'b0);
      check(sum == 12'h000 && err == 1'b0, "R1 zero", int'(sum), 0);

      // R1: digit packing with distinct nibbles, 34+52 = 086
      drive(3, 4, 5, 2, 1'b0);
      check(sum == 12'h086, "R1 packing", int'(sum), 'h086);

      // R7: a change is visible in the same cycle
      drive(0, 1, 0, 2, 1'b0);
      check(sum == 12'h003, "R7 same cycle", int'(sum), 'h003);

      // R2: units total of 19 kept intact
      drive(0, 9, 0, 9, 1'b1);
      check(sum == 12'h019, "R2 total 19", int'(sum), 'h019);

      // R3: boundary 9 gives no carry, 10 gives a carry
      drive(0, 4, 0, 5, 1'b0);
      check(sum == 12'h009, "R3 nine", int'(sum), 'h009);
      drive(0, 5, 0, 5, 1'b0);
      check(sum == 12'h010, "R3 ten", int'(sum), 'h010);

      // R5: cin alone carries through the units digit
      drive(0, 9, 0, 0, 1'b1);
      check(sum == 12'h010, "R5 cin carry", int'(sum), 'h010);

      // R4: ripple of decimal carry into the hundreds digit
      drive(9, 9, 0, 0, 1'b1);
      check(sum == 12'h100, "R4 ripple", int'(sum), 'h100);

      // R8: maximum case
      drive(9, 9, 9, 9, 1'b1);
      check(sum == 12'h199 && err == 1'b0, "R8 max", int'(sum), 'h199);

      // full sweep of valid operands
      for (int av = 0; av < 100; av++) begin
         for (int bv = 0; bv < 100; bv++) begin
            for (int c = 0; c < 2; c++) begin
               valid_case(av / 10, av % 10, bv / 10, bv % 10, bit'(c));
            end
         end
      end

      // R6: each nibble position with each invalid value
      for (int pos = 0; pos < 4; pos++) begin
         for (int v = 10; v < 16; v++) begin
            int n [4];
            n = '{5, 5, 5, 5};
            n[pos] = v;
            drive(n[3], n[2], n[1], n[0], bit'(v & 1));
            check(err == 1'b1, "R6 invalid digit", int'(err), 1);
         end
      end

      // R6: every nibble invalid, then back to valid
      drive(15, 15, 15, 15, 1'b1);
      check(err == 1'b1, "R6 all invalid", int'(err), 1);
      drive(9, 0, 0, 9, 1'b0);
      check(err == 1'b0 && sum == 12'h099, "R6 recover", int'(sum), 'h099);

      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule